// File: doc/BRIEF.md
# Chip-Select Bus Access Sequencer

This block runs read and write cycles on a single chip-select region of an external parallel bus. An internal master issues one request at a time: an address, a write word, a direction flag, a burst flag and a burst length. The sequencer drives the external address, data, chip select and the read and write strobes. It watches an active-low wait input and returns read data with a one-clock done pulse for every word.

A 16-bit control word, held steady by the owner while requests run, sets the shape of every cycle. It selects an 8-bit or 16-bit data path. It adds a programmed number of wait clocks to each burst beat, and it can let the external wait input stretch a beat. It can add one dead clock after a write and, separately, one dead clock after a read. It can also read one word ahead, so that a read of the next word returns without a bus cycle. Addresses are byte addresses, and requests are word aligned.

Top module: `cs_bus_seq`

## Requirements
- R1: After reset, req_ready_o is 1, ext_cs_no, ext_rd_no and ext_wr_no are 1, and done_o is 0.
- R2: With cfg_i[0]=0 (16-bit path), a single access holds chip select and one strobe low for one clock. done_o rises one clock after the accepting edge. A read returns the 16-bit bus word, and a write drives the whole word onto the bus.
- R3: With cfg_i[0]=1 (8-bit path), each word is moved as two byte cycles. The first is at the word address and carries the low byte, and the second is at address+1 and carries the high byte. Both use ext_data_o[7:0] with ext_data_o[15:8] at 0. done_o rises only after the second byte, two clocks after acceptance when no waits apply.
- R4: A burst request with req_len_i=L runs L+1 beats at addresses base+2k. Each beat lasts 1+W clocks per bus cycle, where W=cfg_i[11:8], and each beat gives its own done pulse. A burst write repeats the request word. Non-burst requests get no programmed waits.
- R5: With cfg_i[12]=1, a low ext_wait_ni keeps the current bus cycle, address and strobes unchanged. With cfg_i[12]=0, ext_wait_ni has no effect on timing.
- R6: ext_wait_ni is examined only once the programmed wait clocks of the current bus cycle have run out. A low level during those clocks does not lengthen the beat.
- R7: With cfg_i[14]=1, one clock with chip select high and req_ready_o low follows each write. The bit does not change timing after reads.
- R8: With cfg_i[13]=1, one clock with chip select high and req_ready_o low follows each read. The bit does not change timing after writes.
- R9: With cfg_i[15]=1, a single read is followed by a bus read of the next word (address+2) into a buffer. A single read that hits that address raises done_o in the cycle right after acceptance, with the buffered data and no bus cycle before it.
- R10: With cfg_i[15]=1, a read of any other address uses normal timing. Any accepted request empties the buffer, so a write to the prefetched word followed by a read returns the new data.
- R11: The read and write strobes are never low together and are low only while chip select is low. req_ready_o is 1 only while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 16 | Region control word |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted on this edge when valid |
| req_addr_i | input | AW | Byte address of the first word |
| req_wdata_i | input | 16 | Write word |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_burst_i | input | 1 | Burst request |
| req_len_i | input | LW | Burst beats minus one |
| done_o | output | 1 | One-clock pulse per completed word |
| rdata_o | output | 16 | Read word, valid with done_o |
| ext_addr_o | output | AW | External address |
| ext_data_o | output | 16 | External write data |
| ext_data_oe_o | output | 1 | Write data drive enable |
| ext_data_i | input | 16 | External read data |
| ext_cs_no | output | 1 | Chip select, active low |
| ext_rd_no | output | 1 | Read strobe, active low |
| ext_wr_no | output | 1 | Write strobe, active low |
| ext_wait_ni | input | 1 | External wait, active low |

## Verification
Several rules are checked on every clock: strobe exclusivity and chip-select framing, and that no request is accepted while the bus is active. Others are also checked each clock: that a bus cycle cannot move while an enabled wait is low, that the idle clock after a write or read appears exactly when its bit is set and not otherwise, and that the upper lane stays at zero in byte mode. Cycle counts per beat and byte ordering are shown only by the bench's scenarios. So are the split between programmed and external waits, prefetch hits against misses, and stale-data invalidation. The bench measures done latency against a model memory it keeps itself.

// File: rtl/cs_bus_pkg.sv
package cs_bus_pkg;
  parameter int unsigned CFG_W  = 16;
  parameter int unsigned WORD_W = 16;
  parameter int unsigned BYTE_W = 8;
  parameter int unsigned BWAIT_W = 4;

  typedef struct packed {
    logic               pf_en;
    logic               idle_wr;
    logic               idle_rd;
    logic               xwait_en;
    logic [BWAIT_W-1:0] burst_wait;
    logic               byte_mode;
  } cs_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_GAP} cs_state_e;
endpackage

// File: rtl/cs_cfg_decode.sv
module cs_cfg_decode
  import cs_bus_pkg::*;
#(
  parameter int unsigned PF_BIT = 15,
  parameter int unsigned WI_BIT = 14,
  parameter int unsigned RI_BIT = 13,
  parameter int unsigned XW_BIT = 12,
  parameter int unsigned BW_LSB = 8,
  parameter int unsigned BM_BIT = 0
) (
  input  logic [CFG_W-1:0] cfg_i,
  output cs_cfg_t          cfg_o
);
  localparam logic [CFG_W-1:0] BW_MASK = CFG_W'(((1 << BWAIT_W) - 1) << BW_LSB);
  localparam logic [CFG_W-1:0] USED = BW_MASK | (CFG_W'(1) << PF_BIT) | (CFG_W'(1) << WI_BIT)
                                    | (CFG_W'(1) << RI_BIT) | (CFG_W'(1) << XW_BIT)
                                    | (CFG_W'(1) << BM_BIT);

  logic unused_bits;
  assign unused_bits = ^(cfg_i & ~USED);

  always_comb begin
    cfg_o.pf_en      = cfg_i[PF_BIT];
    cfg_o.idle_wr    = cfg_i[WI_BIT];
    cfg_o.idle_rd    = cfg_i[RI_BIT];
    cfg_o.xwait_en   = cfg_i[XW_BIT];
    cfg_o.burst_wait = cfg_i[BW_LSB +: BWAIT_W];
    cfg_o.byte_mode  = cfg_i[BM_BIT];
  end
endmodule

// File: rtl/cs_wait_ctr.sv
module cs_wait_ctr #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          active_i,
  input  logic          xwait_en_i,
  input  logic          wait_ni,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (active_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  // external wait only looked at once programmed waits are spent
  assign expire_o = active_i && (cnt_q == '0) && (!xwait_en_i || wait_ni);
endmodule

// File: rtl/cs_prefetch_buf.sv
module cs_prefetch_buf #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inval_i,
  input  logic          fill_i,
  input  logic [AW-1:0] fill_addr_i,
  input  logic [DW-1:0] fill_data_i,
  input  logic [AW-1:0] look_addr_i,
  output logic          hit_o,
  output logic [DW-1:0] data_o
);
  logic          vld_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (fill_i) begin
      vld_q  <= 1'b1;
      addr_q <= fill_addr_i;
      data_q <= fill_data_i;
    end else if (inval_i) begin
      vld_q  <= 1'b0;
    end
  end

  assign hit_o  = vld_q && (addr_q == look_addr_i);
  assign data_o = data_q;
endmodule

// File: rtl/cs_bus_seq.sv
module cs_bus_seq
  import cs_bus_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  input  logic              req_write_i,
  input  logic              req_burst_i,
  input  logic [LW-1:0]     req_len_i,
  output logic              done_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic [AW-1:0]     ext_addr_o,
  output logic [WORD_W-1:0] ext_data_o,
  output logic              ext_data_oe_o,
  input  logic [WORD_W-1:0] ext_data_i,
  output logic              ext_cs_no,
  output logic              ext_rd_no,
  output logic              ext_wr_no,
  input  logic              ext_wait_ni
);
  localparam logic [AW-1:0] STEP = AW'(WORD_W / BYTE_W);

  cs_cfg_t cfg;
  cs_state_e st_q;

  logic [AW-1:0]     addr_q;
  logic [WORD_W-1:0] wdata_q, rdata_q, rd_word, pf_data;
  logic [BYTE_W-1:0] lo_q;
  logic [LW-1:0]     beats_q;
  logic write_q, burst_q, pf_run_q, hi_q, done_q;

  logic acc, accept, pf_hit_raw, hit, step_end, word_end, more_beats, to_pf, cont_acc;
  logic wc_load;
  logic [BWAIT_W-1:0] wc_val;

  cs_cfg_decode u_dec (.cfg_i(cfg_i), .cfg_o(cfg));

  assign acc        = (st_q == ST_ACC);
  assign accept     = (st_q == ST_IDLE) && req_valid_i;
  assign hit        = accept && pf_hit_raw && cfg.pf_en && !req_write_i && !req_burst_i;
  assign word_end   = step_end && (!cfg.byte_mode || hi_q);
  assign more_beats = (beats_q != '0);
  assign to_pf      = word_end && !pf_run_q && !write_q && !burst_q && cfg.pf_en && !more_beats;
  assign cont_acc   = !word_end || more_beats || to_pf;
  assign rd_word    = cfg.byte_mode ? {ext_data_i[BYTE_W-1:0], lo_q} : ext_data_i;

  assign wc_load = accept || (step_end && cont_acc);
  always_comb begin
    if (accept) wc_val = (req_burst_i && !hit) ? cfg.burst_wait : '0;
    else        wc_val = burst_q ? cfg.burst_wait : '0;
  end

  cs_wait_ctr #(.CW(BWAIT_W)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wc_load),
    .load_val_i (wc_val),
    .active_i   (acc),
    .xwait_en_i (cfg.xwait_en),
    .wait_ni    (ext_wait_ni),
    .expire_o   (step_end)
  );

  cs_prefetch_buf #(.AW(AW), .DW(WORD_W)) u_pf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .inval_i     (accept),
    .fill_i      (word_end && pf_run_q),
    .fill_addr_i (addr_q),
    .fill_data_i (rd_word),
    .look_addr_i (req_addr_i),
    .hit_o       (pf_hit_raw),
    .data_o      (pf_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      lo_q     <= '0;
      beats_q  <= '0;
      write_q  <= 1'b0;
      burst_q  <= 1'b0;
      pf_run_q <= 1'b0;
      hi_q     <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          st_q    <= ST_ACC;
          hi_q    <= 1'b0;
          write_q <= req_write_i;
          wdata_q <= req_wdata_i;
          if (hit) begin
            done_q   <= 1'b1;
            rdata_q  <= pf_data;
            pf_run_q <= 1'b1;
            burst_q  <= 1'b0;
            beats_q  <= '0;
            addr_q   <= req_addr_i + STEP;
          end else begin
            pf_run_q <= 1'b0;
            burst_q  <= req_burst_i;
            beats_q  <= req_burst_i ? req_len_i : '0;
            addr_q   <= req_addr_i;
          end
        end
        ST_ACC: if (step_end) begin
          if (!word_end) begin
            hi_q <= 1'b1;
            lo_q <= ext_data_i[BYTE_W-1:0];
          end else begin
            hi_q <= 1'b0;
            if (!pf_run_q) begin
              done_q <= 1'b1;
              if (!write_q) rdata_q <= rd_word;
            end
            if (more_beats) begin
              beats_q <= beats_q - 1'b1;
              addr_q  <= addr_q + STEP;
            end else if (to_pf) begin
              pf_run_q <= 1'b1;
              addr_q   <= addr_q + STEP;
            end else begin
              pf_run_q <= 1'b0;
              st_q     <= (write_q ? cfg.idle_wr : cfg.idle_rd) ? ST_GAP : ST_IDLE;
            end
          end
        end
        ST_GAP:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o   = (st_q == ST_IDLE);
  assign done_o        = done_q;
  assign rdata_o       = rdata_q;
  assign ext_addr_o    = addr_q + {{(AW-1){1'b0}}, hi_q};
  assign ext_data_o    = cfg.byte_mode
                       ? {{(WORD_W-BYTE_W){1'b0}}, hi_q ? wdata_q[WORD_W-1:BYTE_W] : wdata_q[BYTE_W-1:0]}
                       : wdata_q;
  assign ext_data_oe_o = acc && write_q;
  assign ext_cs_no     = !acc;
  assign ext_rd_no     = !(acc && !write_q);
  assign ext_wr_no     = !(acc && write_q);
endmodule

// File: rtl/cs_bus_seq_chk.sv
module cs_bus_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] cfg_i,
  input logic        req_ready_o,
  input logic [15:0] ext_addr_o,
  input logic [15:0] ext_data_o,
  input logic        ext_cs_no,
  input logic        ext_rd_no,
  input logic        ext_wr_no,
  input logic        ext_wait_ni
);
  p_strobe_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_rd_no || ext_wr_no));

  p_strobe_in_cs_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_rd_no || !ext_wr_no) |-> !ext_cs_no);

  p_ready_bus_free_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> ext_cs_no);

  p_xwait_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_cs_no && cfg_i[12] && !ext_wait_ni) |=> (!ext_cs_no && $stable(ext_addr_o)));

  p_wr_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ext_cs_no) && $past(!ext_wr_no) && cfg_i[14]) |-> !req_ready_o);

  p_wr_nogap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ext_cs_no) && $past(!ext_wr_no) && !cfg_i[14]) |-> req_ready_o);

  p_rd_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ext_cs_no) && $past(!ext_rd_no) && cfg_i[13]) |-> !req_ready_o);

  p_rd_nogap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ext_cs_no) && $past(!ext_rd_no) && !cfg_i[13]) |-> req_ready_o);

  p_byte_lane_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_wr_no && cfg_i[0]) |-> (ext_data_o[15:8] == 8'h00));
endmodule

bind cs_bus_seq cs_bus_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_i       (cfg_i),
  .req_ready_o (req_ready_o),
  .ext_addr_o  (ext_addr_o),
  .ext_data_o  (ext_data_o),
  .ext_cs_no   (ext_cs_no),
  .ext_rd_no   (ext_rd_no),
  .ext_wr_no   (ext_wr_no),
  .ext_wait_ni (ext_wait_ni)
);

// File: tb/cs_bus_seq_tb_top.sv
module cs_bus_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] cfg = '0, req_addr = '0, req_wdata = '0, rdata, ext_addr, ext_dout, ext_din;
  logic req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0, ready, done;
  logic [3:0] req_len = '0;
  logic ext_oe, ext_cs_n, ext_rd_n, ext_wr_n, ext_wait_n = 1'b1;

  cs_bus_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg),
    .req_valid_i(req_valid), .req_ready_o(ready), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_write_i(req_write), .req_burst_i(req_burst),
    .req_len_i(req_len), .done_o(done), .rdata_o(rdata),
    .ext_addr_o(ext_addr), .ext_data_o(ext_dout), .ext_data_oe_o(ext_oe),
    .ext_data_i(ext_din), .ext_cs_no(ext_cs_n), .ext_rd_no(ext_rd_n),
    .ext_wr_no(ext_wr_n), .ext_wait_ni(ext_wait_n)
  );

  typedef struct {
    bit          w;
    logic [15:0] d;
    int          acc;
    int          lat;
    string       tag;
  } item_t;
  item_t sb_q[$];

  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  int cyc = 0, nvec = 0, nfail = 0, hold = 0;
  logic [15:0] start_addr = '0;
  logic cs_prev = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  // external memory model
  always @(posedge clk) if (!ext_wr_n) begin
    if (cfg[0]) mem[ext_addr[7:0]] = ext_dout[7:0];
    else begin
      mem[{ext_addr[7:1], 1'b0}] = ext_dout[7:0];
      mem[{ext_addr[7:1], 1'b1}] = ext_dout[15:8];
    end
  end
  assign ext_din = cfg[0] ? {8'h00, mem[ext_addr[7:0]]}
                          : {mem[{ext_addr[7:1], 1'b1}], mem[{ext_addr[7:1], 1'b0}]};

  // wait generator: hold low for 'hold' cycles of active chip select
  always @(negedge clk) begin
    if (!ext_cs_n && hold > 0) begin ext_wait_n = 1'b0; hold = hold - 1; end
    else ext_wait_n = 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (cs_prev && !ext_cs_n) start_addr = ext_addr;
    cs_prev = ext_cs_n;
    if (rst_n && done) begin
      if (sb_q.size() == 0) chk(1'b0, "R2 unexpected done", 1, 0);
      else begin
        item_t it;
        it = sb_q.pop_front();
        if (!it.w) chk(rdata == it.d, {it.tag, " data"}, int'(rdata), int'(it.d));
        if (it.lat >= 0) chk((cyc - it.acc) == it.lat, {it.tag, " latency"}, cyc - it.acc, it.lat);
      end
    end
  end

  task automatic issue(input bit w, input bit b, input int len, input logic [15:0] a,
                       input logic [15:0] d, input int beat_lat, input int extra, input string tag);
    int acc;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_burst = b; req_len = 4'(len);
    req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    acc = cyc;
    req_valid = 1'b0;
    for (int k = 0; k < (b ? len + 1 : 1); k++) begin
      item_t it;
      logic [7:0] ba;
      ba = 8'(a + 16'(2 * k));
      if (w) begin ref_mem[ba] = d[7:0]; ref_mem[8'(ba + 1)] = d[15:8]; end
      it.w = w;
      it.d = w ? d : {ref_mem[8'(ba + 1)], ref_mem[ba]};
      it.acc = acc;
      it.lat = (k + 1) * beat_lat + extra;
      it.tag = tag;
      sb_q.push_back(it);
    end
  endtask

  task automatic set_cfg(input logic [15:0] c);
    @(negedge clk);
    while (!ready || sb_q.size() != 0) @(negedge clk);
    cfg = c;
  endtask

  task automatic gap_probe(input bit w, input bit exp_rdy, input string tag);
    issue(w, 1'b0, 0, 16'h00C0, 16'h5A5A, 1, 0, tag);
    @(negedge clk);
    while (!done) @(negedge clk);
    chk(ready == exp_rdy, tag, int'(ready), int'(exp_rdy));
    @(negedge clk);
    chk(ready == 1'b1, {tag, " recover"}, int'(ready), 1);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 50000) begin
    nfail++;
    $display("FAIL watchdog R1 actual=%0d expected<%0d", cyc, 50000);
    report();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ready && ext_cs_n && ext_rd_n && ext_wr_n && !done, "R1 reset outputs",
        int'({ready, ext_cs_n, ext_rd_n, ext_wr_n, done}), 'b11110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready && ext_cs_n && !done, "R1 after release", int'({ready, ext_cs_n, done}), 'b110);

    // R2 16-bit single access
    set_cfg(16'h0000);
    issue(0, 0, 0, 16'h0010, 16'h0, 1, 0, "R2 read");
    issue(1, 0, 0, 16'h0012, 16'hBEEF, 1, 0, "R2 write");
    issue(0, 0, 0, 16'h0012, 16'h0, 1, 0, "R2 readback");

    // R3 8-bit path
    set_cfg(16'h0001);
    issue(1, 0, 0, 16'h0020, 16'hA55A, 2, 0, "R3 byte write");
    set_cfg(16'h0001);
    chk(start_addr == 16'h0020, "R3 low byte first address", int'(start_addr), 'h20);
    chk(mem[8'h20] == 8'h5A && mem[8'h21] == 8'hA5, "R3 byte placement",
        int'({mem[8'h21], mem[8'h20]}), 'hA55A);
    issue(0, 0, 0, 16'h0020, 16'h0, 2, 0, "R3 byte read");
    issue(0, 0, 0, 16'h0034, 16'h0, 2, 0, "R3 byte read 2");

    // R4 bursts
    set_cfg(16'h0200);
    issue(0, 1, 3, 16'h0040, 16'h0, 3, 0, "R4 burst read");
    issue(1, 1, 2, 16'h0060, 16'h1234, 3, 0, "R4 burst write");
    issue(0, 0, 0, 16'h0064, 16'h0, 1, 0, "R4 single no waits");
    set_cfg(16'h0101);
    issue(0, 1, 1, 16'h0070, 16'h0, 4, 0, "R4 byte burst");

    // R5 external wait
    set_cfg(16'h1000);
    hold = 3;
    issue(0, 0, 0, 16'h0010, 16'h0, 1, 3, "R5 wait honoured");
    set_cfg(16'h0000);
    hold = 3;
    issue(0, 0, 0, 16'h0014, 16'h0, 1, 0, "R5 wait ignored");
    set_cfg(16'h0000);
    hold = 0;

    // R6 wait sampled after programmed waits
    set_cfg(16'h1300);
    hold = 2;
    issue(0, 1, 0, 16'h0016, 16'h0, 4, 0, "R6 early wait absorbed");
    set_cfg(16'h1300);
    hold = 5;
    issue(0, 1, 0, 16'h0018, 16'h0, 4, 2, "R6 late wait extends");
    set_cfg(16'h0000);
    hold = 0;

    // R7 / R8 idle clocks
    set_cfg(16'h4000);
    gap_probe(1, 0, "R7 gap after write");
    gap_probe(0, 1, "R7 no gap after read");
    set_cfg(16'h2000);
    gap_probe(0, 0, "R8 gap after read");
    gap_probe(1, 1, "R8 no gap after write");

    // R9 / R10 prefetch
    set_cfg(16'h8000);
    issue(0, 0, 0, 16'h0080, 16'h0, 1, 0, "R9 first read");
    issue(0, 0, 0, 16'h0082, 16'h0, 0, 0, "R9 hit");
    issue(0, 0, 0, 16'h0084, 16'h0, 0, 0, "R9 chained hit");
    issue(0, 0, 0, 16'h0090, 16'h0, 1, 0, "R10 miss");
    issue(0, 0, 0, 16'h00A0, 16'h0, 1, 0, "R10 other address");
    issue(1, 0, 0, 16'h00A2, 16'h7777, 1, 0, "R10 write invalidates");
    issue(0, 0, 0, 16'h00A2, 16'h0, 1, 0, "R10 fresh data");

    set_cfg(16'h0000);
    begin
      int bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) bad++;
      chk(bad == 0, "R2 R4 memory image", bad, 0);
    end
    report();
  end
endmodule